// File: doc/BRIEF.md
# Flash Program/Erase Session Controller

This block sits between a CPU-style write bus and the high-voltage sequencing of an on-chip flash array. Software opens a session, picks program or erase, and then writes to the array. In program mode each array write fills a page buffer slot, and the first write of the session also fixes which page will be programmed. In erase mode any array write arms an interlock. Software then sets the high-voltage enable bit. The block passes a one-cycle start request and the timing settings to an external pulse timer, and drops high voltage when that timer reports done.

While a session is open, the timing, protection and block-select settings and the mode bits cannot be changed. Closing the session releases everything.

Array writes carry a word address `arr_waddr[15:0]`, which is byte address bits 17..2 (bit 0 is the least significant):

| `arr_waddr` bits | Byte address bits | Meaning |
|---|---|---|
| [15:13] | 17..15 | Block |
| [12:4] | 14..6 | Page offset |
| [3:0] | 5..2 | Word within the page |

Top module: `flash_seq_ctl`

## Requirements
- R1: After reset all four configuration registers read 0, `hv_on`, `pulse_start` and `irq` are 0, and every page buffer slot reads 0.
- R2: Register map (`cfg_addr`) is as follows.
  - 0 CTRL: bit0 session, bit1 hv enable, bit2 erase select, bit3 CSC, bit4 irq enable, bit5 done (write 1 to clear), bit6 access error (write 1 to clear).
  - 1 TIMING: [2:0] prescale, [4:3] exponent, [11:5] multiplier. This register drives `pulse_cfg`.
  - 2 PROT: [7:0] protection, [15:8] block select.
  - 3 PAGE (read-only): [8:0] page offset, bit9 page valid, bit10 interlock.

  While the session bit is 1, writes to TIMING and PROT are ignored.
- R3: While a session is open, writes cannot change erase select or CSC. Irq enable cannot change either while erase select is 0. With erase select at 1, irq enable stays writable. A CTRL write that opens a session still updates these bits.
- R4: In program mode, the first array write of a session latches `arr_waddr[12:4]` as the page offset and sets page valid. Later writes in the same session leave the page offset unchanged.
- R5: Each accepted program-mode write stores `arr_wdata` in slot {`arr_waddr[15:13]`, `arr_waddr[3:0]`}. The slot is readable on `buf_rdata` when `buf_raddr` selects it.
- R6: A CTRL write with bits 0 and 1 set, made while a session is open in program mode, sets hv enable. `hv_on` then rises and `pulse_start` is 1 for exactly one cycle. Program writes are ignored while hv enable is 1.
- R7: In erase mode, a request to set hv enable is ignored until an array write has set the interlock bit. After the interlock is set, the same request is accepted. Erase-mode array writes never touch the page buffer.
- R8: While hv enable is 1, `pulse_done` clears it and sets the done flag. `irq` equals done AND irq enable. Writing 1 to CTRL bit5 clears done.
- R9: An array write while no session is open changes no buffer slot and sets the access-error flag. Writing 1 to CTRL bit6 clears that flag.
- R10: A CTRL write with bit0 clear, made during a session, closes it. This clears hv enable, the interlock, page valid, the page offset and all buffer slots, and unlocks the locked fields.
- R11: A CTRL write from the closed state never sets hv enable, even if bit1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for write and read |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| arr_we | input | 1 | Array write strobe |
| arr_waddr | input | 16 | Array word address (byte address bits 17..2) |
| arr_wdata | input | 32 | Array write data |
| buf_raddr | input | 7 | Page buffer slot to read |
| buf_rdata | output | 32 | Page buffer slot contents |
| pulse_start | output | 1 | One-cycle start request to the pulse timer |
| hv_on | output | 1 | High-voltage enable state |
| pulse_cfg | output | 12 | Timing settings for the pulse timer |
| pulse_done | input | 1 | Pulse timer completion |
| irq | output | 1 | Completion interrupt |

## Verification
The properties assume that `cfg_we` and `arr_we` are never high in the same cycle. They also assume that `pulse_done` comes only from the timer's own sequence and is not held high across a new start. The bench keeps to this by issuing one bus operation per cycle through tasks, and by pulsing `pulse_done` for a single cycle only while high voltage is on. Random array addresses and data cover the whole 16-bit word-address space, so page and slot selection see arbitrary bit patterns. Random TIMING writes made during a session are attempted only while the session bit is held at 1.

// File: rtl/flash_seq_ctl.sv
module flash_seq_ctl #(
  parameter int DW   = 32,
  parameter int PG_W = 9,
  parameter int WS_W = 4,
  parameter int BS_W = 3,
  parameter int WA_W = BS_W + PG_W + WS_W,
  parameter int SL_W = BS_W + WS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [15:0]     cfg_wdata,
  output logic [15:0]     cfg_rdata,
  input  logic            arr_we,
  input  logic [WA_W-1:0] arr_waddr,
  input  logic [DW-1:0]   arr_wdata,
  input  logic [SL_W-1:0] buf_raddr,
  output logic [DW-1:0]   buf_rdata,
  output logic            pulse_start,
  output logic            hv_on,
  output logic [11:0]     pulse_cfg,
  input  logic            pulse_done,
  output logic            irq
);
  localparam int NSLOT = 1 << SL_W;

  logic ses, ehv, pe, csc, sie, done, err, start, ilk, pvalid;
  logic [PG_W-1:0] page;
  logic [11:0]     tim;
  logic [15:0]     prot;
  logic [DW-1:0]   bufm [NSLOT];

  wire [SL_W-1:0] slot   = {arr_waddr[WA_W-1 -: BS_W], arr_waddr[WS_W-1:0]};
  wire            closing = cfg_we && cfg_addr == 2'd0 && ses && !cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ses, ehv, pe, csc, sie, done, err, start, ilk, pvalid} <= '0;
      page <= '0;
      tim  <= '0;
      prot <= '0;
      for (int i = 0; i < NSLOT; i++) bufm[i] <= '0;
    end else begin
      start <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: begin
            if (!ses) begin
              pe  <= cfg_wdata[2];
              csc <= cfg_wdata[3];
            end
            if (!ses || pe) sie <= cfg_wdata[4];
            ses <= cfg_wdata[0];
            if (cfg_wdata[5]) done <= 1'b0;
            if (cfg_wdata[6]) err  <= 1'b0;
            if (closing) begin
              ehv    <= 1'b0;
              ilk    <= 1'b0;
              pvalid <= 1'b0;
              page   <= '0;
              for (int i = 0; i < NSLOT; i++) bufm[i] <= '0;
            end else if (ses && cfg_wdata[1] && !ehv && (!pe || ilk)) begin
              ehv   <= 1'b1;
              start <= 1'b1;
            end
          end
          2'd1: if (!ses) tim <= cfg_wdata[11:0];
          2'd2: if (!ses) prot <= cfg_wdata;
          default: ;
        endcase
      end
      if (arr_we) begin
        if (!ses) err <= 1'b1;
        else if (pe) ilk <= 1'b1;
        else if (!ehv) begin
          bufm[slot] <= arr_wdata;
          if (!pvalid) begin
            pvalid <= 1'b1;
            page   <= arr_waddr[WS_W +: PG_W];
          end
        end
      end
      if (ehv && pulse_done) begin
        ehv  <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {9'd0, err, done, sie, csc, pe, ehv, ses};
      2'd1:    cfg_rdata = {4'd0, tim};
      2'd2:    cfg_rdata = prot;
      default: cfg_rdata = 16'({ilk, pvalid, page});
    endcase
  end

  assign buf_rdata   = bufm[buf_raddr];
  assign pulse_start = start;
  assign hv_on       = ehv;
  assign pulse_cfg   = tim;
  assign irq         = sie & done;
endmodule

module flash_seq_ctl_chk #(parameter int PG_W = 9) (
  input logic            clk,
  input logic            rst_n,
  input logic            ses,
  input logic            ehv,
  input logic            pe,
  input logic            sie,
  input logic            ilk,
  input logic            pvalid,
  input logic            start,
  input logic            arr_we,
  input logic            err,
  input logic [11:0]     tim,
  input logic [15:0]     prot,
  input logic [PG_W-1:0] page
);
  // R2
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ses && $past(ses)) |-> ($stable(tim) && $stable(prot)));
  // R3
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ses && $past(ses)) |-> $stable(pe));
  // R3
  sie_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ses && $past(ses) && !$past(pe)) |-> $stable(sie));
  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ses && $past(ses) && $past(pvalid)) |-> $stable(page));
  // R7
  erase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ehv) |-> ($past(ilk) || !$past(pe)));
  // R6
  start_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ehv);
  // R11
  hv_sess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ehv |-> ses);
  // R9
  acc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !ses) |=> err);
endmodule

bind flash_seq_ctl flash_seq_ctl_chk #(.PG_W(PG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ses(ses), .ehv(ehv), .pe(pe), .sie(sie),
  .ilk(ilk), .pvalid(pvalid), .start(start), .arr_we(arr_we), .err(err),
  .tim(tim), .prot(prot), .page(page)
);

// File: tb/flash_seq_ctl_tb_top.sv
module flash_seq_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        arr_we = 1'b0;
  logic [15:0] arr_waddr = '0;
  logic [31:0] arr_wdata = '0;
  logic [6:0]  buf_raddr = '0;
  logic [31:0] buf_rdata;
  logic        pulse_start, hv_on, irq, pulse_done = 1'b0;
  logic [11:0] pulse_cfg;

  int n_cmp = 0, n_err = 0;
  logic [31:0] exp_buf [128];
  logic [8:0]  exp_page;
  logic [15:0] v;

  always #5 clk = ~clk;

  flash_seq_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .buf_raddr(buf_raddr),
    .buf_rdata(buf_rdata), .pulse_start(pulse_start), .hv_on(hv_on),
    .pulse_cfg(pulse_cfg), .pulse_done(pulse_done), .irq(irq)
  );

  function automatic logic [6:0] slot_of(logic [15:0] a);
    return {a[15:13], a[3:0]};
  endfunction
  function automatic logic [8:0] page_of(logic [15:0] a);
    return a[12:4];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [1:0] a, logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic arr_wr(logic [15:0] a, logic [31:0] d);
    arr_we = 1'b1; arr_waddr = a; arr_wdata = d;
    @(posedge clk); @(negedge clk);
    arr_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] r);
    cfg_addr = a; #1; r = cfg_rdata;
  endtask

  task automatic rd_buf(logic [6:0] s, output logic [31:0] r);
    buf_raddr = s; #1; r = buf_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] b;
    logic [15:0] a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) exp_buf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 4; r++) begin rd(2'(r), v); chk("R1 reg", 32'(v), 0); end
    chk("R1 hv_on", 32'(hv_on), 0);
    chk("R1 pulse_start", 32'(pulse_start), 0);
    chk("R1 irq", 32'(irq), 0);
    rd_buf(7'd5, b); chk("R1 buf", b, 0);

    arr_wr(16'h0025, 32'hDEAD_BEEF);
    rd(2'd0, v); chk("R9 err set", 32'(v[6]), 1);
    rd_buf(slot_of(16'h0025), b); chk("R9 buf untouched", b, 0);
    cfg_wr(2'd0, 16'h0040);
    rd(2'd0, v); chk("R9 err clear", 32'(v), 0);

    cfg_wr(2'd1, 16'h00AB);
    cfg_wr(2'd2, 16'h1234);
    chk("R2 pulse_cfg", 32'(pulse_cfg), 32'h0AB);
    cfg_wr(2'd0, 16'h0019);
    rd(2'd0, v); chk("R3 open ctrl", 32'(v), 32'h19);
    for (int i = 0; i < 6; i++) begin
      cfg_wr(2'd1, 16'($urandom));
      rd(2'd1, v); chk("R2 timing locked", 32'(v), 32'h0AB);
    end
    cfg_wr(2'd2, 16'hFFFF);
    rd(2'd2, v); chk("R2 prot locked", 32'(v), 32'h1234);
    cfg_wr(2'd0, 16'h0005);
    rd(2'd0, v); chk("R3 mode bits locked", 32'(v), 32'h19);

    a = 16'($urandom); b = $urandom;
    arr_wr(a, b); exp_buf[slot_of(a)] = b; exp_page = page_of(a);
    for (int i = 0; i < 40; i++) begin
      a = 16'($urandom); b = $urandom;
      arr_wr(a, b); exp_buf[slot_of(a)] = b;
    end
    arr_wr(16'hFFF0, 32'h1111_2222); exp_buf[slot_of(16'hFFF0)] = 32'h1111_2222;
    rd(2'd3, v); chk("R4 page latched", 32'(v), 32'(16'h0200 | 16'(exp_page)));
    for (int s = 0; s < 128; s++) begin
      rd_buf(7'(s), b); chk("R5 buf slot", b, exp_buf[s]);
    end

    cfg_wr(2'd0, 16'h001B);
    chk("R6 pulse_start", 32'(pulse_start), 1);
    chk("R6 hv_on", 32'(hv_on), 1);
    @(negedge clk);
    chk("R6 pulse_start one cycle", 32'(pulse_start), 0);
    arr_wr(16'h0003, 32'hABCD_0000);
    rd_buf(7'd3, b); chk("R6 write rejected", b, exp_buf[3]);

    pulse_done = 1'b1; @(negedge clk); pulse_done = 1'b0;
    chk("R8 hv_on cleared", 32'(hv_on), 0);
    rd(2'd0, v); chk("R8 done set", 32'(v), 32'h39);
    chk("R8 irq", 32'(irq), 1);
    cfg_wr(2'd0, 16'h0039);
    rd(2'd0, v); chk("R8 done clear", 32'(v), 32'h19);
    chk("R8 irq low", 32'(irq), 0);

    cfg_wr(2'd0, 16'h0018);
    rd(2'd0, v); chk("R10 closed", 32'(v), 32'h18);
    rd(2'd3, v); chk("R10 page cleared", 32'(v), 0);
    rd_buf(slot_of(16'hFFF0), b); chk("R10 buf released", b, 0);
    cfg_wr(2'd1, 16'h0155);
    rd(2'd1, v); chk("R10 unlocked", 32'(v), 32'h155);

    cfg_wr(2'd0, 16'h0005);
    rd(2'd0, v); chk("R3 erase open", 32'(v), 32'h05);
    cfg_wr(2'd0, 16'h0007);
    chk("R7 hv refused", 32'(hv_on), 0);
    chk("R7 no start", 32'(pulse_start), 0);
    cfg_wr(2'd0, 16'h0015);
    rd(2'd0, v); chk("R3 sie writable in erase", 32'(v), 32'h15);
    arr_wr(16'h0042, 32'h5555_5555);
    rd(2'd3, v); chk("R7 interlock", 32'(v), 32'h400);
    rd_buf(slot_of(16'h0042), b); chk("R7 buf untouched", b, 0);
    cfg_wr(2'd0, 16'h0017);
    chk("R7 hv accepted", 32'(hv_on), 1);
    cfg_wr(2'd0, 16'h0000);
    chk("R10 hv dropped", 32'(hv_on), 0);
    rd(2'd0, v); chk("R10 ctrl after close", 32'(v), 32'h04);
    rd(2'd3, v); chk("R10 interlock cleared", 32'(v), 0);

    cfg_wr(2'd0, 16'h0003);
    chk("R11 hv not set", 32'(hv_on), 0);
    rd(2'd0, v); chk("R11 ctrl", 32'(v), 32'h01);

    finish_run();
  end
endmodule